// File: doc/BRIEF.md
# Three-Bit Function-Code ALU

This block is a purely combinational N-bit arithmetic logic unit. A 3-bit function code picks one of six operations: AND, OR, addition and subtraction, and AND and OR taken against the complement of the second operand. The top function bit is shared by every operation. It first decides whether the B operand passes through unchanged or inverted, and it also serves as the carry into the adder. Subtraction is therefore an addition of A to the two's complement of B, with no separate subtractor.

The adder is built from carry-lookahead groups whose group carries are chained. The unit produces a result word and three flags. Carry-out and signed overflow are valid for the two arithmetic codes and are held at zero for every other code. The zero flag describes the selected result. The two codes with no assigned operation drive a result of all zeros and clear both arithmetic flags. The block is intended as the execute stage of a small datapath, and any registering is done by the surrounding logic.

Top module: `alu3op`

## Requirements
- R1: Function code 000 gives `y_o = a_i & b_i`, and code 001 gives `y_o = a_i | b_i`.
- R2: Function code 100 gives `y_o = a_i & ~b_i`, and code 101 gives `y_o = a_i | ~b_i`.
- R3: Function code 010 gives `y_o = (a_i + b_i) mod 2^WIDTH`, and `carry_o` equals bit WIDTH of the full sum.
- R4: Function code 110 gives `y_o = (a_i - b_i) mod 2^WIDTH`, formed as `a_i + ~b_i + 1`. `carry_o` is 1 exactly when `a_i >= b_i` as unsigned values.
- R5: For codes 010 and 110, `ovf_o` is 1 exactly when the two adder operands (`a_i`, and either `b_i` or `~b_i`) have the same sign bit and the sign bit of the result differs from it. Operands of opposite sign never set it.
- R6: For the logic codes 000, 001, 100 and 101, `carry_o` and `ovf_o` are 0.
- R7: The unused codes 011 and 111 give `y_o = 0`, `carry_o = 0` and `ovf_o = 0`.
- R8: `zero_o` is 1 exactly when every bit of `y_o` is 0, for every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand, inverted when fn_i[2] is 1 |
| fn_i | input | 3 | Function code; bit 2 inverts B and supplies the carry-in, bits 1:0 select the result |
| y_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Adder carry-out for arithmetic codes, else 0 |
| ovf_o | output | 1 | Two's-complement overflow for arithmetic codes, else 0 |
| zero_o | output | 1 | Result is all zeros |

## Verification
The ALU is driven with uniformly random operand pairs spread over all eight function codes. This exercises the lookahead carries across group boundaries and separates the inverted-B codes from the plain ones. Directed pairs cover cases that random draws seldom reach. They include the largest positive value plus one and the most negative value minus one, which must overflow, and mixed-sign additions, which must not. Equal operands under subtraction must give a zero result with carry set. Borrow cases must clear the carry, and all-ones operands must ripple a carry through every group. The unused codes are applied with non-zero operands, so that any leakage of a logic or sum result into the output would show.

// File: rtl/alu3op_pkg.sv
// Package: alu3op_pkg
// Shared function-code type for the three-bit ALU. Bit 2 of each code
// selects B or ~B and is also the adder carry-in; bits 1:0 pick the
// result source. This layout is decoded directly by the datapath.
package alu3op_pkg;

    typedef enum logic [2:0] {
        FN_AND    = 3'b000,
        FN_OR     = 3'b001,
        FN_ADD    = 3'b010,
        FN_NONE0  = 3'b011,
        FN_ANDN   = 3'b100,
        FN_ORN    = 3'b101,
        FN_SUB    = 3'b110,
        FN_NONE1  = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_AND  = 2'b00,
        SRC_OR   = 2'b01,
        SRC_SUM  = 2'b10,
        SRC_NONE = 2'b11
    } alu_src_e;

endpackage

// File: rtl/alu3op_bcond.sv
// Module: alu3op_bcond
// Conditions the B operand: passes it unchanged or bitwise inverted,
// according to the invert control. Assumes nothing about operand values.
module alu3op_bcond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] b_o
);

    // Select true or inverted operand, bit by bit.
    always_comb begin
        b_o = inv_i ? ~b_i : b_i;
    end

endmodule

// File: rtl/alu3op_logic.sv
// Module: alu3op_logic
// Bitwise AND and OR of A with the already-conditioned B operand.
// Assumes B has been inverted upstream when the complement forms are wanted.
module alu3op_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);

    // Form both logic results in parallel.
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
    end

endmodule

// File: rtl/alu3op_cla.sv
// Module: alu3op_cla
// Carry-lookahead adder split into groups of GROUP bits. Each group
// computes its internal carries in flattened lookahead form and exports
// group generate/propagate terms; group carries are chained between
// groups. Reports carry-out and the carry into the sign bit for overflow.
// Assumes WIDTH >= 2; a final short group is allowed.
module alu3op_cla #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;
    logic [WIDTH-1:0] cbit_w;     // carry into each bit
    logic [NGRP-1:0]  grp_g;
    logic [NGRP-1:0]  grp_p;
    logic [NGRP:0]    grp_c;      // carry into each group, last = carry-out

    // Per-bit generate and propagate terms.
    always_comb begin
        gen_w  = a_i & b_i;
        prop_w = a_i ^ b_i;
    end

    // Chain the group carries from group generate/propagate.
    always_comb begin
        grp_c[0] = cin_i;
        for (int k = 0; k < NGRP; k++) begin
            grp_c[k+1] = grp_g[k] | (grp_p[k] & grp_c[k]);
        end
    end

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int BASE = gi * GROUP;
        localparam int GW   = (WIDTH - BASE < GROUP) ? (WIDTH - BASE) : GROUP;

        logic [GW-1:0] cin_loc;
        logic          gg_loc;
        logic          gp_loc;

        // Flattened lookahead carries inside the group, from its carry-in.
        always_comb begin
            logic term;
            logic run;
            for (int i = 0; i < GW; i++) begin
                term = 1'b0;
                run  = 1'b1;
                for (int j = i - 1; j >= 0; j--) begin
                    term = term | (run & gen_w[BASE+j]);
                    run  = run & prop_w[BASE+j];
                end
                cin_loc[i] = term | (run & grp_c[gi]);
            end
        end

        // Group generate and propagate over all bits of the group.
        always_comb begin
            logic term;
            logic run;
            term = 1'b0;
            run  = 1'b1;
            for (int j = GW - 1; j >= 0; j--) begin
                term = term | (run & gen_w[BASE+j]);
                run  = run & prop_w[BASE+j];
            end
            gg_loc = term;
            gp_loc = run;
        end

        assign cbit_w[BASE +: GW] = cin_loc;
        assign grp_g[gi]          = gg_loc;
        assign grp_p[gi]          = gp_loc;
    end

    // Sum bits and sign-column flags.
    always_comb begin
        sum_o  = prop_w ^ cbit_w;
        cout_o = grp_c[NGRP];
        ovf_o  = grp_c[NGRP] ^ cbit_w[WIDTH-1];
    end

endmodule

// File: rtl/alu3op_outsel.sv
// Module: alu3op_outsel
// Chooses the result from the AND, OR or sum path by the low two function
// bits; the fourth source yields zeros. Arithmetic flags pass only for the
// sum source. Derives the zero flag from the chosen result.
module alu3op_outsel
    import alu3op_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       sel_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    input  logic             ovf_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);

    alu_src_e src;
    assign src = alu_src_e'(sel_i);

    // Result multiplexer and flag gating.
    always_comb begin
        y_o     = '0;
        carry_o = 1'b0;
        ovf_o   = 1'b0;
        unique case (src)
            SRC_AND:  y_o = and_i;
            SRC_OR:   y_o = or_i;
            SRC_SUM: begin
                y_o     = sum_i;
                carry_o = cout_i;
                ovf_o   = ovf_i;
            end
            default:  y_o = '0;
        endcase
        zero_o = ~|y_o;
    end

endmodule

// File: rtl/alu3op.sv
// Module: alu3op (top)
// Combinational ALU selected by a 3-bit function code. Bit 2 inverts B
// for every operation and is the adder carry-in; bits 1:0 select AND,
// OR, sum or zeros. No clock or reset: outputs settle from inputs.
module alu3op #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       fn_i,
    output logic [WIDTH-1:0] y_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    logic             ovf_w;

    alu3op_bcond #(.WIDTH(WIDTH)) u_bcond (
        .b_i   (b_i),
        .inv_i (fn_i[2]),
        .b_o   (b_eff)
    );

    alu3op_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_eff),
        .and_o (and_w),
        .or_o  (or_w)
    );

    alu3op_cla #(.WIDTH(WIDTH), .GROUP(GROUP)) u_cla (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (fn_i[2]),
        .sum_o  (sum_w),
        .cout_o (cout_w),
        .ovf_o  (ovf_w)
    );

    alu3op_outsel #(.WIDTH(WIDTH)) u_outsel (
        .sel_i   (fn_i[1:0]),
        .and_i   (and_w),
        .or_i    (or_w),
        .sum_i   (sum_w),
        .cout_i  (cout_w),
        .ovf_i   (ovf_w),
        .y_o     (y_o),
        .carry_o (carry_o),
        .ovf_o   (ovf_o),
        .zero_o  (zero_o)
    );

endmodule

// File: rtl/alu3op_chk.sv
// Module: alu3op_chk
// Property checker for alu3op. The block has no clock, so the checks are
// immediate assertions evaluated whenever the ports settle.
module alu3op_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       fn_i,
    input logic [WIDTH-1:0] y_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             zero_o
);

    // Port-level relations between operands, code and outputs.
    always_comb begin
        if (fn_i == 3'b000) begin
            a_r1_and: assert ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0);
        end
        if (fn_i == 3'b101) begin
            a_r2_orn: assert ((y_o & a_i) == a_i && (y_o & ~b_i) == ~b_i);
        end
        if (fn_i == 3'b110 && a_i == b_i) begin
            a_r4_sub_equal: assert (y_o == '0 && carry_o && zero_o);
        end
        if (fn_i == 3'b010 && a_i[WIDTH-1] != b_i[WIDTH-1]) begin
            a_r5_no_overflow: assert (!ovf_o);
        end
        if (fn_i[1] == 1'b0) begin
            a_r6_logic_flags: assert (!carry_o && !ovf_o);
        end
        if (fn_i[1:0] == 2'b11) begin
            a_r7_unused: assert (y_o == '0 && !carry_o && !ovf_o && zero_o);
        end
    end

endmodule

bind alu3op alu3op_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .fn_i    (fn_i),
    .y_o     (y_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o)
);

// File: tb/alu3op_test.sv
// Bench for alu3op: random and directed vectors against a bench-side model.
module alu3op_test;

    localparam int WIDTH = 16;
    localparam int NRAND = 3000;
    localparam logic [WIDTH-1:0] MAXP = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MINN = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [WIDTH-1:0] a, b, y;
    logic [2:0]       fn;
    logic             cy, ov, zr;

    int checks = 0;
    int errors = 0;

    alu3op #(.WIDTH(WIDTH), .GROUP(4)) uut (
        .a_i(a), .b_i(b), .fn_i(fn),
        .y_o(y), .carry_o(cy), .ovf_o(ov), .zero_o(zr)
    );

    // Expected result from the requirements.
    function automatic logic [WIDTH-1:0] exp_y(input logic [WIDTH-1:0] ea,
                                               input logic [WIDTH-1:0] eb,
                                               input logic [2:0] ef);
        logic [WIDTH-1:0] bb;
        bb = ef[2] ? ~eb : eb;
        case (ef[1:0])
            2'b00:   return ea & bb;
            2'b01:   return ea | bb;
            2'b10:   return ef[2] ? ea - eb : ea + eb;
            default: return '0;
        endcase
    endfunction

    // Expected carry: full sum bit for add, no-borrow for subtract.
    function automatic logic exp_c(input logic [WIDTH-1:0] ea,
                                   input logic [WIDTH-1:0] eb,
                                   input logic [2:0] ef);
        logic [WIDTH:0] s;
        if (ef == 3'b010) begin
            s = {1'b0, ea} + {1'b0, eb};
            return s[WIDTH];
        end
        if (ef == 3'b110) return (ea >= eb);
        return 1'b0;
    endfunction

    // Expected overflow by the operand/result sign rule.
    function automatic logic exp_v(input logic [WIDTH-1:0] ea,
                                   input logic [WIDTH-1:0] eb,
                                   input logic [2:0] ef);
        logic [WIDTH-1:0] bb, r;
        if (ef[1:0] != 2'b10) return 1'b0;
        bb = ef[2] ? ~eb : eb;
        r  = exp_y(ea, eb, ef);
        return (ea[WIDTH-1] == bb[WIDTH-1]) && (r[WIDTH-1] != ea[WIDTH-1]);
    endfunction

    function automatic string tag_of(input logic [2:0] ef);
        case (ef)
            3'b000, 3'b001: return "R1";
            3'b100, 3'b101: return "R2";
            3'b010:         return "R3";
            3'b110:         return "R4";
            default:        return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: a=%h b=%h fn=%b actual=%h expected=%h",
                     tag, what, a, b, fn, act, exp);
        end
    endtask

    // Drive one vector away from the clock edge and compare all outputs.
    task automatic run(input logic [WIDTH-1:0] ta, input logic [WIDTH-1:0] tb,
                       input logic [2:0] tf);
        @(negedge clk);
        a = ta; b = tb; fn = tf;
        #2;
        chk(tag_of(tf), "result", y, exp_y(ta, tb, tf));
        if (tf[1:0] == 2'b10)
            chk(tag_of(tf), "carry", {{(WIDTH-1){1'b0}}, cy},
                {{(WIDTH-1){1'b0}}, exp_c(ta, tb, tf)});
        else
            chk(tf[1:0] == 2'b11 ? "R7" : "R6", "carry",
                {{(WIDTH-1){1'b0}}, cy}, '0);
        chk(tf[1:0] == 2'b10 ? "R5" : (tf[1:0] == 2'b11 ? "R7" : "R6"), "overflow",
            {{(WIDTH-1){1'b0}}, ov}, {{(WIDTH-1){1'b0}}, exp_v(ta, tb, tf)});
        chk("R8", "zero", {{(WIDTH-1){1'b0}}, zr},
            {{(WIDTH-1){1'b0}}, (exp_y(ta, tb, tf) == '0)});
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        a = '0; b = '0; fn = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands, AND code -> zero result, zero flag set (R8).
        run('0, '0, 3'b000);

        // R1 / R2 directed patterns.
        run(16'hF0F0, 16'h3C3C, 3'b000);
        run(16'hF0F0, 16'h3C3C, 3'b001);
        run(16'hF0F0, 16'h3C3C, 3'b100);
        run(16'h0000, 16'hFFFF, 3'b101);   // OR with ~B gives zero: R8
        // R3: carry through every group, and plain carry-out.
        run(ONES, 16'h0001, 3'b010);
        run(16'h1234, 16'h4321, 3'b010);
        // R4: equal, borrow, no borrow.
        run(16'h5A5A, 16'h5A5A, 3'b110);
        run(16'h0003, 16'h0007, 3'b110);
        run(16'h0007, 16'h0003, 3'b110);
        // R5: overflow corners and mixed-sign non-overflow.
        run(MAXP, 16'h0001, 3'b010);
        run(MINN, 16'h0001, 3'b110);
        run(MINN, ONES, 3'b010);
        run(MAXP, MINN, 3'b010);
        run(MAXP, ONES, 3'b110);
        run(16'h0000, MINN, 3'b110);
        // R7: unused codes with live operands.
        run(ONES, ONES, 3'b011);
        run(16'hA5A5, 16'h5A5A, 3'b111);

        // Random sweep over all codes.
        for (int n = 0; n < NRAND; n++) begin
            run(WIDTH'($urandom), WIDTH'($urandom), 3'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule